// File: doc/BRIEF.md
# March BIST controller

This block runs a built-in self-test of an attached single-port memory. It drives one memory operation per clock through a march algorithm that is built into the block. The algorithm is a list of elements. An element either idles the memory for a fixed retention interval, or sweeps every address in rising or falling order. During a sweep it applies a short list of writes and expected-value reads to each cell before it moves to the next address.

Every read is compared against the data the algorithm expects. The first mismatch is recorded with its address and element number. The run always goes on to the end of the algorithm. After that a done flag stays high until the next start. Four algorithms are provided and one is chosen by a select input at start:

- a ten-operations-per-cell sequence;
- a five-operations-per-cell sequence;
- that five-op sequence with a read-back after each inner write, aimed at cells that cannot be accessed;
- the five-op sequence with retention idles before the reads of each state.

Top module: `march_bist`

## Requirements
- R1: While reset is held, and after reset until the first start, done and fail are 0 and neither mem_we nor mem_re is asserted.
- R2: alg_sel is sampled only in the cycle in which start is accepted, in idle or after done. The codes are 0 = ten-op, 1 = five-op, 2 = five-op with read-back, 3 = five-op with retention. A start pulse or an alg_sel change during a run has no effect on that run.
- R3: In a sweep element, one operation is issued per clock with no gap. All operations of the element are applied to one address before the address changes. Exactly one of mem_we and mem_re is high in each such cycle. A write drives every data bit with the operation's value.
- R4: A rising sweep visits addresses 0 to 2^ADDR_W-1. A falling sweep visits 2^ADDR_W-1 down to 0. An element whose order does not matter uses rising order.
- R5: Code 0 runs, with elements numbered 0 to 5: write 0 rising; rising read 0 then write 1; rising read 1 then write 0; falling read 0 then write 1; falling read 1 then write 0; rising read 0.
- R6: Code 1 runs: element 0 write 0 rising; element 1 rising read 0 then write 1; element 2 falling read 1 then write 0.
- R7: Code 2 runs: element 0 write 0 rising; element 1 rising read 0, write 1, read 1; element 2 falling read 1, write 0, read 0.
- R8: Code 3 runs: element 0 write 0 rising; element 1 idle; element 2 rising read 0 then write 1; element 3 idle; element 4 falling read 1 then write 0. Each idle element lasts exactly WAIT_CYCLES clocks with no memory operation.
- R9: mem_rdata is taken one clock after the read is issued and compared with the expected bit on all data bits. The first mismatch of a run sets fail and stores its address in fail_addr and its element number in fail_elem. Element numbers count idle elements too. Later mismatches change none of these.
- R10: done goes high two clocks after the cycle of the last operation and holds until start. A start accepted while done is high clears done and fail on the next clock and begins a new run.
- R11: A run reaches done after the same number of cycles whether or not a mismatch was found.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begins a run when idle or done |
| alg_sel | input | 2 | Algorithm code, sampled at start |
| mem_addr | output | ADDR_W | Memory address of the current operation |
| mem_we | output | 1 | Write strobe |
| mem_re | output | 1 | Read strobe; data expected one clock later |
| mem_wdata | output | DATA_W | Write data, all bits equal |
| mem_rdata | input | DATA_W | Read data from the memory |
| done | output | 1 | Run finished |
| fail | output | 1 | At least one read mismatched |
| fail_addr | output | ADDR_W | Address of the first mismatch |
| fail_elem | output | 3 | Element number of the first mismatch |

## Verification
The bench attaches a behavioural memory and injects one fault per run: stuck-at bits, cells that cannot rise, idempotent coupling from an aggressor's rising write, or a bit that decays during long idles. Fault-free runs compare the exact operation trace against each algorithm's element list, which shows whether the sweep order and per-cell operation order are right. Faulty runs tell apart algorithms that detect a fault from ones that miss it. For example, a decaying cell is caught only by the retention code, with a hand-computed address and element. Randomized runs check fail, address, element and completion time against a reference march executed in the bench over an identical faulty copy.

// File: rtl/march_pkg.sv
package march_pkg;

    localparam int ELEM_W = 3;

    typedef enum logic [1:0] {
        ALG_TEN      = 2'd0,
        ALG_FIVE     = 2'd1,
        ALG_FIVE_RB  = 2'd2,
        ALG_FIVE_RET = 2'd3
    } alg_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RUN,
        ST_HOLD,
        ST_DRAIN,
        ST_DONE
    } st_e;

    // one step of the algorithm: op i uses bit i of is_wr / val
    typedef struct packed {
        logic       last;
        logic       hold;
        logic       down;
        logic [1:0] lastop;
        logic [2:0] is_wr;
        logic [2:0] val;
    } elem_t;

    function automatic elem_t mk_elem(input logic last, input logic hold, input logic down,
                                      input logic [1:0] lastop, input logic [2:0] is_wr,
                                      input logic [2:0] val);
        elem_t e;
        e.last   = last;
        e.hold   = hold;
        e.down   = down;
        e.lastop = lastop;
        e.is_wr  = is_wr;
        e.val    = val;
        return e;
    endfunction

endpackage

// File: rtl/march_elem_rom.sv
module march_elem_rom
    import march_pkg::*;
(
    input  logic [1:0]        alg,
    input  logic [ELEM_W-1:0] idx,
    output elem_t             elem
);

    always_comb begin
        elem = mk_elem(1'b1, 1'b0, 1'b0, 2'd0, 3'b001, 3'b000);
        if (idx == '0) begin
            // every algorithm opens with a rising write-0 sweep
            elem = mk_elem(1'b0, 1'b0, 1'b0, 2'd0, 3'b001, 3'b000);
        end else begin
            case (alg_e'(alg))
                ALG_TEN: begin
                    case (idx)
                        3'd1: elem = mk_elem(1'b0, 1'b0, 1'b0, 2'd1, 3'b010, 3'b010);
                        3'd2: elem = mk_elem(1'b0, 1'b0, 1'b0, 2'd1, 3'b010, 3'b001);
                        3'd3: elem = mk_elem(1'b0, 1'b0, 1'b1, 2'd1, 3'b010, 3'b010);
                        3'd4: elem = mk_elem(1'b0, 1'b0, 1'b1, 2'd1, 3'b010, 3'b001);
                        3'd5: elem = mk_elem(1'b1, 1'b0, 1'b0, 2'd0, 3'b000, 3'b000);
                        default: ;
                    endcase
                end
                ALG_FIVE: begin
                    case (idx)
                        3'd1: elem = mk_elem(1'b0, 1'b0, 1'b0, 2'd1, 3'b010, 3'b010);
                        3'd2: elem = mk_elem(1'b1, 1'b0, 1'b1, 2'd1, 3'b010, 3'b001);
                        default: ;
                    endcase
                end
                ALG_FIVE_RB: begin
                    case (idx)
                        3'd1: elem = mk_elem(1'b0, 1'b0, 1'b0, 2'd2, 3'b010, 3'b110);
                        3'd2: elem = mk_elem(1'b1, 1'b0, 1'b1, 2'd2, 3'b010, 3'b001);
                        default: ;
                    endcase
                end
                default: begin
                    case (idx)
                        3'd1: elem = mk_elem(1'b0, 1'b1, 1'b0, 2'd0, 3'b000, 3'b000);
                        3'd2: elem = mk_elem(1'b0, 1'b0, 1'b0, 2'd1, 3'b010, 3'b010);
                        3'd3: elem = mk_elem(1'b0, 1'b1, 1'b0, 2'd0, 3'b000, 3'b000);
                        3'd4: elem = mk_elem(1'b1, 1'b0, 1'b1, 2'd1, 3'b010, 3'b001);
                        default: ;
                    endcase
                end
            endcase
        end
    end

endmodule

// File: rtl/march_resp_cmp.sv
module march_resp_cmp
    import march_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              rd_issue,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic              rd_exp,
    input  logic [ELEM_W-1:0] rd_elem,
    input  logic [DATA_W-1:0] rdata,
    output logic              fail,
    output logic [ADDR_W-1:0] fail_addr,
    output logic [ELEM_W-1:0] fail_elem
);

    typedef struct packed {
        logic              pend;
        logic [ADDR_W-1:0] paddr;
        logic              pexp;
        logic [ELEM_W-1:0] pelem;
        logic              fail;
        logic [ADDR_W-1:0] faddr;
        logic [ELEM_W-1:0] felem;
    } cmp_t;

    cmp_t cmp_d, cmp_q;

    always_comb begin
        cmp_d       = cmp_q;
        cmp_d.pend  = rd_issue;
        cmp_d.paddr = rd_addr;
        cmp_d.pexp  = rd_exp;
        cmp_d.pelem = rd_elem;
        if (clr) begin
            cmp_d.fail  = 1'b0;
            cmp_d.faddr = '0;
            cmp_d.felem = '0;
        end else if (cmp_q.pend && !cmp_q.fail && (rdata != {DATA_W{cmp_q.pexp}})) begin
            cmp_d.fail  = 1'b1;
            cmp_d.faddr = cmp_q.paddr;
            cmp_d.felem = cmp_q.pelem;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cmp_q <= '0;
        else        cmp_q <= cmp_d;
    end

    assign fail      = cmp_q.fail;
    assign fail_addr = cmp_q.faddr;
    assign fail_elem = cmp_q.felem;

endmodule

// File: rtl/march_bist.sv
module march_bist
    import march_pkg::*;
#(
    parameter int ADDR_W      = 4,
    parameter int DATA_W      = 8,
    parameter int WAIT_CYCLES = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [1:0]        alg_sel,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_we,
    output logic              mem_re,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              done,
    output logic              fail,
    output logic [ADDR_W-1:0] fail_addr,
    output logic [ELEM_W-1:0] fail_elem
);

    localparam int                CNT_W    = $clog2(WAIT_CYCLES + 1);
    localparam logic [ADDR_W-1:0] ADDR_TOP = '1;
    localparam logic [CNT_W-1:0]  CNT_END  = CNT_W'(WAIT_CYCLES - 1);

    typedef struct packed {
        st_e               st;
        logic [1:0]        alg;
        logic [ELEM_W-1:0] elem;
        logic [1:0]        op;
        logic [ADDR_W-1:0] addr;
        logic [CNT_W-1:0]  wcnt;
    } ctl_t;

    ctl_t              ctl_d, ctl_q;
    elem_t             cur, nxt;
    logic              busy;
    logic              accept;
    logic [1:0]        nxt_alg;
    logic [ELEM_W-1:0] nxt_idx;
    logic              rd_issue;
    logic              op_wr;
    logic              op_val;

    assign busy    = (ctl_q.st == ST_RUN) || (ctl_q.st == ST_HOLD) || (ctl_q.st == ST_DRAIN);
    assign accept  = start && !busy;
    assign nxt_alg = busy ? ctl_q.alg : alg_sel;
    assign nxt_idx = busy ? ELEM_W'(ctl_q.elem + 1'b1) : '0;

    march_elem_rom u_rom_cur (
        .alg  (ctl_q.alg),
        .idx  (ctl_q.elem),
        .elem (cur)
    );

    march_elem_rom u_rom_nxt (
        .alg  (nxt_alg),
        .idx  (nxt_idx),
        .elem (nxt)
    );

    assign op_wr  = cur.is_wr[ctl_q.op];
    assign op_val = cur.val[ctl_q.op];

    always_comb begin
        ctl_d     = ctl_q;
        mem_we    = 1'b0;
        mem_re    = 1'b0;
        mem_wdata = '0;
        rd_issue  = 1'b0;
        case (ctl_q.st)
            ST_RUN: begin
                mem_we    = op_wr;
                mem_re    = !op_wr;
                rd_issue  = !op_wr;
                mem_wdata = {DATA_W{op_val}};
                if (ctl_q.op != cur.lastop) begin
                    ctl_d.op = 2'(ctl_q.op + 1'b1);
                end else begin
                    ctl_d.op = '0;
                    if (ctl_q.addr != (cur.down ? '0 : ADDR_TOP)) begin
                        ctl_d.addr = cur.down ? ADDR_W'(ctl_q.addr - 1'b1)
                                              : ADDR_W'(ctl_q.addr + 1'b1);
                    end else if (cur.last) begin
                        ctl_d.st = ST_DRAIN;
                    end else begin
                        ctl_d.elem = nxt_idx;
                        if (nxt.hold) begin
                            ctl_d.st   = ST_HOLD;
                            ctl_d.wcnt = '0;
                        end else begin
                            ctl_d.addr = nxt.down ? ADDR_TOP : '0;
                        end
                    end
                end
            end
            ST_HOLD: begin
                if (ctl_q.wcnt == CNT_END) begin
                    ctl_d.st   = ST_RUN;
                    ctl_d.elem = nxt_idx;
                    ctl_d.op   = '0;
                    ctl_d.addr = nxt.down ? ADDR_TOP : '0;
                end else begin
                    ctl_d.wcnt = CNT_W'(ctl_q.wcnt + 1'b1);
                end
            end
            ST_DRAIN: ctl_d.st = ST_DONE;
            default: begin
                if (start) begin
                    ctl_d.st   = ST_RUN;
                    ctl_d.alg  = alg_sel;
                    ctl_d.elem = '0;
                    ctl_d.op   = '0;
                    ctl_d.wcnt = '0;
                    ctl_d.addr = nxt.down ? ADDR_TOP : '0;
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q    <= '0;
            ctl_q.st <= ST_IDLE;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    march_resp_cmp #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_cmp (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (accept),
        .rd_issue  (rd_issue),
        .rd_addr   (ctl_q.addr),
        .rd_exp    (op_val),
        .rd_elem   (ctl_q.elem),
        .rdata     (mem_rdata),
        .fail      (fail),
        .fail_addr (fail_addr),
        .fail_elem (fail_elem)
    );

    assign mem_addr = ctl_q.addr;
    assign done     = (ctl_q.st == ST_DONE);

endmodule

// File: rtl/march_bist_chk.sv
module march_bist_chk #(
    parameter int ADDR_W = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic              mem_we,
    input logic              mem_re,
    input logic              done,
    input logic              fail,
    input logic [ADDR_W-1:0] fail_addr,
    input logic [2:0]        fail_elem
);

    AST_ONE_OP: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_we && mem_re)); // R3

    AST_DONE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !(mem_we || mem_re)); // R10

    AST_DONE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> done); // R10

    AST_RESTART_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (done && start) |=> (!done && !fail)); // R10

    AST_DONE_AFTER_DRAIN: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> $past(!(mem_we || mem_re))); // R10

    AST_FIRST_FAIL_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (fail && !start) |=> (fail && $stable(fail_addr) && $stable(fail_elem))); // R9

endmodule

bind march_bist march_bist_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .mem_we    (mem_we),
    .mem_re    (mem_re),
    .done      (done),
    .fail      (fail),
    .fail_addr (fail_addr),
    .fail_elem (fail_elem)
);

// File: tb/march_bist_tb.sv
module march_bist_tb;

    localparam int AW    = 4;
    localparam int DW    = 8;
    localparam int WAITC = 16;
    localparam int DEPTH = 1 << AW;
    localparam int MAXOP = 512;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [1:0]    alg_sel = 2'd0;
    logic [AW-1:0] mem_addr;
    logic          mem_we, mem_re;
    logic [DW-1:0] mem_wdata;
    logic [DW-1:0] mem_rdata = '0;
    logic          done, fail;
    logic [AW-1:0] fail_addr;
    logic [2:0]    fail_elem;

    always #5 clk = ~clk;

    march_bist #(.ADDR_W(AW), .DATA_W(DW), .WAIT_CYCLES(WAITC)) u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .alg_sel(alg_sel),
        .mem_addr(mem_addr), .mem_we(mem_we), .mem_re(mem_re),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .done(done), .fail(fail), .fail_addr(fail_addr), .fail_elem(fail_elem)
    );

    int nchk = 0;
    int nerr = 0;

    // fault: 0 none, 1 stuck bit, 2 bit cannot rise, 3 coupling, 4 decay in idle
    int ftype = 0, fa = 0, fb = 0, fagg = 0;
    bit fv = 1'b0;

    logic [DW-1:0] mem [2][DEPTH];
    int idle_cnt = 0;

    // expected trace from the bench reference
    bit e_we [MAXOP];
    bit e_re [MAXOP];
    int e_addr [MAXOP];
    bit e_dat [MAXOP];
    int e_len;
    bit exp_fail;
    int exp_addr, exp_elem;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int expv);
        nchk++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, expv);
        end
    endtask

    function automatic void mwrite(input int s, input int a, input logic [DW-1:0] d);
        logic [DW-1:0] old;
        logic [DW-1:0] nw;
        old = mem[s][a];
        nw  = d;
        if (ftype == 2 && a == fa && !old[fb] && nw[fb]) nw[fb] = 1'b0;
        mem[s][a] = nw;
        if (ftype == 3 && a == fagg && !old[0] && nw[0]) mem[s][fa][0] = fv;
        if (ftype == 1) mem[s][fa][fb] = fv;
    endfunction

    function automatic void decay(input int s);
        if (ftype == 4) mem[s][fa][fb] = 1'b0;
    endfunction

    // element list written from R5..R8: {last, idle, falling, lastop[1:0], wr[2:0], val[2:0]}
    function automatic logic [10:0] tb_elem(input int alg, input int e);
        logic [10:0] r;
        r = {1'b1, 1'b0, 1'b0, 2'd0, 3'b001, 3'b000};
        if (e == 0) r = {1'b0, 1'b0, 1'b0, 2'd0, 3'b001, 3'b000};
        else if (alg == 0) begin
            case (e)
                1: r = {1'b0, 1'b0, 1'b0, 2'd1, 3'b010, 3'b010};
                2: r = {1'b0, 1'b0, 1'b0, 2'd1, 3'b010, 3'b001};
                3: r = {1'b0, 1'b0, 1'b1, 2'd1, 3'b010, 3'b010};
                4: r = {1'b0, 1'b0, 1'b1, 2'd1, 3'b010, 3'b001};
                default: r = {1'b1, 1'b0, 1'b0, 2'd0, 3'b000, 3'b000};
            endcase
        end else if (alg == 1) begin
            if (e == 1) r = {1'b0, 1'b0, 1'b0, 2'd1, 3'b010, 3'b010};
            else        r = {1'b1, 1'b0, 1'b1, 2'd1, 3'b010, 3'b001};
        end else if (alg == 2) begin
            if (e == 1) r = {1'b0, 1'b0, 1'b0, 2'd2, 3'b010, 3'b110};
            else        r = {1'b1, 1'b0, 1'b1, 2'd2, 3'b010, 3'b001};
        end else begin
            case (e)
                1, 3: r = {1'b0, 1'b1, 1'b0, 2'd0, 3'b000, 3'b000};
                2: r = {1'b0, 1'b0, 1'b0, 2'd1, 3'b010, 3'b010};
                default: r = {1'b1, 1'b0, 1'b1, 2'd1, 3'b010, 3'b001};
            endcase
        end
        return r;
    endfunction

    function automatic void ref_run(input int alg);
        logic [10:0] el;
        e_len = 0;
        exp_fail = 1'b0;
        exp_addr = 0;
        exp_elem = 0;
        for (int e = 0; e < 8; e++) begin
            el = tb_elem(alg, e);
            if (el[9]) begin
                for (int i = 0; i < WAITC; i++) begin
                    e_we[e_len] = 1'b0; e_re[e_len] = 1'b0; e_addr[e_len] = 0; e_dat[e_len] = 1'b0;
                    e_len++;
                end
                decay(1);
            end else begin
                for (int k = 0; k < DEPTH; k++) begin
                    int a;
                    a = el[8] ? DEPTH - 1 - k : k;
                    for (int o = 0; o <= int'(el[7:6]); o++) begin
                        bit w, v;
                        w = el[3 + o];
                        v = el[o];
                        if (w) mwrite(1, a, {DW{v}});
                        else if (mem[1][a] !== {DW{v}} && !exp_fail) begin
                            exp_fail = 1'b1; exp_addr = a; exp_elem = e;
                        end
                        e_we[e_len] = w; e_re[e_len] = !w; e_addr[e_len] = a; e_dat[e_len] = v;
                        e_len++;
                    end
                end
            end
            if (el[10]) break;
        end
    endfunction

    // behavioural memory with one-clock read latency
    always @(posedge clk) begin
        if (mem_we) mwrite(0, int'(mem_addr), mem_wdata);
        if (mem_re) mem_rdata <= mem[0][mem_addr];
        if (!mem_we && !mem_re) begin
            idle_cnt++;
            if (idle_cnt == 8) decay(0);
        end else begin
            idle_cnt = 0;
        end
    end

    task automatic run_one(input int alg, input bit hand, input bit h_fail, input int h_addr,
                           input int h_elem, input int h_len, input bit poke);
        string rq;
        int k, bad, bad_k;
        rq = (alg == 0) ? "R5" : (alg == 1) ? "R6" : (alg == 2) ? "R7" : "R8";
        for (int a = 0; a < DEPTH; a++) begin
            logic [DW-1:0] r;
            r = DW'($urandom);
            mem[0][a] = r;
            mem[1][a] = r;
        end
        if (ftype == 1) begin
            mem[0][fa][fb] = fv;
            mem[1][fa][fb] = fv;
        end
        ref_run(alg);
        if (hand) begin
            exp_fail = h_fail; exp_addr = h_addr; exp_elem = h_elem;
            chk(e_len == h_len, rq, "reference length", e_len, h_len);
        end
        @(negedge clk);
        start = 1'b1;
        alg_sel = 2'(alg);
        @(posedge clk);
        #1;
        start = 1'b0;
        alg_sel = 2'($urandom);     // R2: ignored after start
        chk(!done && !fail, "R10", "restart clears done/fail", {30'd0, done, fail}, 0);
        k = 1; bad = 0; bad_k = 0;
        while (!done && k < 2000) begin
            if (k <= e_len) begin
                int i;
                i = k - 1;
                if (mem_we !== e_we[i] || mem_re !== e_re[i]) bad++;
                else if ((e_we[i] || e_re[i]) && int'(mem_addr) != e_addr[i]) bad++;
                else if (e_we[i] && mem_wdata !== {DW{e_dat[i]}}) bad++;
                if (bad != 0 && bad_k == 0) bad_k = k;
            end else if (mem_we || mem_re) begin
                bad++;
                if (bad_k == 0) bad_k = k;
            end
            if (poke && k == 20) start = 1'b1;   // R2: start during a run
            if (poke && k == 21) start = 1'b0;
            @(posedge clk);
            #1;
            k++;
        end
        chk(bad == 0, poke ? "R2" : "R3", {rq, " R4 operation trace, first bad cycle"}, bad_k, 0);
        chk(k == e_len + 2, exp_fail ? "R11" : "R10", "cycles to done", k, e_len + 2);
        chk(fail == exp_fail, "R9", "fail flag", fail, exp_fail);
        if (exp_fail && fail) begin
            chk(int'(fail_addr) == exp_addr, "R9", "first fail address", fail_addr, exp_addr);
            chk(int'(fail_elem) == exp_elem, "R9", "first fail element", fail_elem, exp_elem);
        end
        repeat (3) @(posedge clk);
        #1;
        chk(done && !mem_we && !mem_re, "R10", "done held, memory quiet",
            {29'd0, done, mem_we, mem_re}, 4);
    endtask

    initial begin
        repeat (1000000) @(posedge clk);
        nerr++;
        $display("FAIL R10 watchdog: actual=%0d expected=%0d", 0, 1);
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(posedge clk);
        #1;
        chk(!done && !fail && !mem_we && !mem_re, "R1", "outputs in reset",
            {28'd0, done, fail, mem_we, mem_re}, 0);
        @(negedge clk);
        rst_n = 1'b1;
        repeat (4) @(posedge clk);
        #1;
        chk(!done && !fail && !mem_we && !mem_re, "R1", "idle after reset",
            {28'd0, done, fail, mem_we, mem_re}, 0);

        // R8: decaying bit at address 5 caught by retention code in falling element 4
        ftype = 4; fa = 5; fb = 2;
        run_one(3, 1'b1, 1'b1, 5, 4, 5 * DEPTH + 2 * WAITC, 1'b0);
        // R6: same fault escapes the plain five-op code
        run_one(1, 1'b1, 1'b0, 0, 0, 5 * DEPTH, 1'b0);
        // R6: stuck-0 at address 3 seen by the falling read-1 of element 2
        ftype = 1; fa = 3; fb = 0; fv = 1'b0;
        run_one(1, 1'b1, 1'b1, 3, 2, 5 * DEPTH, 1'b0);
        // R5: stuck-1 at address 3 seen by the rising read-0 of element 1
        fv = 1'b1;
        run_one(0, 1'b1, 1'b1, 3, 1, 10 * DEPTH, 1'b0);
        // R7 and R2: clean memory, stray start pulse mid-run
        ftype = 0;
        run_one(2, 1'b1, 1'b0, 0, 0, 7 * DEPTH, 1'b1);

        for (int n = 0; n < 16; n++) begin
            ftype = int'($urandom % 5);
            fa    = int'($urandom % DEPTH);
            fb    = int'($urandom % DW);
            fv    = 1'($urandom);
            fagg  = (fa + 1 + int'($urandom % (DEPTH - 1))) % DEPTH;
            run_one(int'($urandom % 4), 1'b0, 1'b0, 0, 0, 0, 1'b0);
        end

        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

endmodule